// File: doc/BRIEF.md
# SPI Controller Register and FIFO Front End

This block sits between a 32-bit register port and the shift engine of an SPI master. Software writes transmit words into a queue, the shift engine takes them one at a time, and words it receives go into a second queue that software drains. Both queues hold eight 32-bit words. The block also keeps the configuration words the shift engine needs (clock divider and phase, word formats, frame select) and drives them straight out on configuration ports.

Software sets a receive threshold equal to the burst length it queued. When the receive queue fills to that count, a sticky receive-complete flag is raised. A second flag is raised if the engine delivers a word while the receive queue has no room, and that word is lost. A third flag is raised when the transmit queue runs dry. Each flag is cleared by writing a one to its bit. A single interrupt line is the OR of the flags that are enabled. Reads and writes at one address reach both data queues, and the interrupt flags are read and cleared at one shared address.

Top module: `spi_fifo_regs`

## Requirements
- R1: After a synchronous reset every register reads 0, both queues are empty, `irq` is 0, `tx_avail` is 0 and `reg_rdata` is 0.
- R2: Word offsets 0x04, 0x08, 0x0C and 0x10 store and return all 32 written bits and drive `cfg_clock`, `cfg_tx_word`, `cfg_rx_word` and `cfg_frame`. Offset 0x00 keeps only bit 0, which drives `cfg_enable`. A read of an unmapped or misaligned address (offset beyond 0x24, or with address bits 1:0 not zero) returns 0.
- R3: A write to 0x24 appends to the transmit queue in order. A write to a full queue (8 words) is dropped. `tx_avail` is high while the queue holds a word, `tx_data` shows the oldest word, and `tx_pop` removes it.
- R4: The engine appends words with `rx_push`. A read of 0x24 returns the oldest word and removes it. A read with the queue empty returns 0 and changes nothing. Bit 0 of 0x14 is 1 while the receive queue holds a word.
- R5: A push into a full receive queue with no pop in the same cycle is dropped and sets the overrun flag, bit 0 of 0x1C.
- R6: A push that raises the receive count to exactly the receive threshold (bits 3:0 of 0x20, nonzero) sets the receive-complete flag, bit 3 of 0x1C. Bit 9 of 0x1C reads as the receive-not-empty state.
- R7: A pop that empties the transmit queue, with no write to 0x24 in the same cycle, sets the transmit-complete flag, bit 4 of 0x1C.
- R8: Writing 0x1C clears each of flag bits 4, 3 and 0 written as 1 and leaves the others alone. A flag set in the same cycle as its clear ends up set.
- R9: Offset 0x18 keeps bit 3 (receive-complete enable) and bit 0 (overrun enable). `irq` equals (bit 3 and receive-complete) or (bit 0 and overrun) and follows the flag registers with no added delay.
- R10: In 0x20, writing 1 to bit 12 or bit 4 empties the transmit or receive queue at the clock edge after the write. Both bits read back 0. Bits 11:8 and 3:0 hold the transmit and receive thresholds and read back as written.
- R11: While bit 0 of 0x00 is 0, `tx_pop` and `rx_push` are ignored, and no overrun is flagged.
- R12: `reg_rdata` is registered. It shows the value read in the cycle after `reg_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tx_pop | input | 1 | Engine takes the oldest transmit word |
| tx_data | output | 32 | Oldest transmit word |
| tx_avail | output | 1 | Transmit queue holds a word |
| rx_push | input | 1 | Engine delivers a received word |
| rx_data | input | 32 | Received word |
| cfg_enable | output | 1 | Block enable |
| cfg_clock | output | 32 | Clock divider and phase settings |
| cfg_tx_word | output | 32 | Transmit word format |
| cfg_rx_word | output | 32 | Receive word format |
| cfg_frame | output | 32 | Frame select settings |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the receive queue past eight words. A design that let the ninth push wrap a pointer would overwrite the oldest word and show it out of order, or never raise the overrun flag. It reads the data port with the queue empty, where a wrong design would return stale data or slip its read pointer. It issues flushes and then reads the control word back, and sets a flag in the same cycle software clears it. A design with the wrong priority would lose the event, and one that flushed late or kept the flush bits would show words that should be gone. Disabled pushes and pops are checked through the status and data ports.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 6;
    localparam int THR_W   = 4;

    // word index of each register (byte offset / 4)
    typedef enum logic [3:0] {
        RG_CTRL = 4'd0,
        RG_CLK  = 4'd1,
        RG_TXW  = 4'd2,
        RG_RXW  = 4'd3,
        RG_FRM  = 4'd4,
        RG_STAT = 4'd5,
        RG_IEN  = 4'd6,
        RG_IST  = 4'd7,
        RG_FCTL = 4'd8,
        RG_DATA = 4'd9
    } reg_idx_e;

    // bit positions
    localparam int B_ROR      = 0;
    localparam int B_RC       = 3;
    localparam int B_TXC      = 4;
    localparam int B_RXRDY    = 9;
    localparam int B_RXFLUSH  = 4;
    localparam int B_TXFLUSH  = 12;
    localparam int B_RXTHR_LO = 0;
    localparam int B_TXTHR_LO = 8;

    typedef struct packed {
        logic txc;
        logic rc;
        logic ror;
    } irq_flags_t;

    function automatic logic is_reg(input logic [ADDR_W-1:0] a, input reg_idx_e r);
        return (a[1:0] == 2'b00) && (a[ADDR_W-1:2] == r);
    endfunction

endpackage

// File: rtl/spi_sfifo.sv
module spi_sfifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr,
    input  logic                           push,
    input  logic [WIDTH-1:0]               push_data,
    input  logic                           pop,
    output logic [WIDTH-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty,
    output logic                           push_ok,
    output logic                           pop_ok
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign pop_ok  = pop && !empty && !clr;
    assign push_ok = push && (!full || pop_ok) && !clr;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

endmodule

// File: rtl/spi_irq_ctl.sv
module spi_irq_ctl
    import spi_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  irq_flags_t set_flags,
    input  logic       clr_we,
    input  irq_flags_t clr_flags,
    input  logic       en_rc,
    input  logic       en_ror,
    output irq_flags_t flags,
    output logic       irq
);
    irq_flags_t clr_mask;

    assign clr_mask = clr_we ? clr_flags : '0;

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_mask) | set_flags;
    end

    assign irq = (en_rc && flags.rc) || (en_ror && flags.ror);

    // R8
    rc_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_flags.rc |=> flags.rc);

    // R8
    ror_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_mask.ror && !set_flags.ror) |=> !flags.ror);

endmodule

// File: rtl/spi_fifo_regs.sv
module spi_fifo_regs
    import spi_regs_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tx_pop,
    output logic [31:0]       tx_data,
    output logic              tx_avail,
    input  logic              rx_push,
    input  logic [31:0]       rx_data,
    output logic              cfg_enable,
    output logic [31:0]       cfg_clock,
    output logic [31:0]       cfg_tx_word,
    output logic [31:0]       cfg_rx_word,
    output logic [31:0]       cfg_frame,
    output logic              irq
);
    localparam int CW = $clog2(FIFO_DEPTH+1);

    // configuration and control state
    logic             ctl_en;
    logic [REG_W-1:0] clk_cfg, txw_cfg, rxw_cfg, frm_cfg;
    logic             ie_rc, ie_ror;
    logic [THR_W-1:0] tx_thr, rx_thr;
    logic             tx_flush_q, rx_flush_q;
    logic [REG_W-1:0] rdata_q;

    // decode
    logic wr_ctrl, wr_clk, wr_txw, wr_rxw, wr_frm, wr_ien, wr_ist, wr_fctl, wr_data;
    logic rd_data;

    assign wr_ctrl = reg_wr && is_reg(reg_addr, RG_CTRL);
    assign wr_clk  = reg_wr && is_reg(reg_addr, RG_CLK);
    assign wr_txw  = reg_wr && is_reg(reg_addr, RG_TXW);
    assign wr_rxw  = reg_wr && is_reg(reg_addr, RG_RXW);
    assign wr_frm  = reg_wr && is_reg(reg_addr, RG_FRM);
    assign wr_ien  = reg_wr && is_reg(reg_addr, RG_IEN);
    assign wr_ist  = reg_wr && is_reg(reg_addr, RG_IST);
    assign wr_fctl = reg_wr && is_reg(reg_addr, RG_FCTL);
    assign wr_data = reg_wr && is_reg(reg_addr, RG_DATA);
    assign rd_data = reg_rd && is_reg(reg_addr, RG_DATA);

    // queues
    logic [31:0]   tx_head, rx_head;
    logic [CW-1:0] tx_count, rx_count;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic          tx_pop_eff, rx_push_eff;

    assign tx_pop_eff  = ctl_en && tx_pop;
    assign rx_push_eff = ctl_en && rx_push;

    spi_sfifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .clr(tx_flush_q),
        .push(wr_data), .push_data(reg_wdata), .pop(tx_pop_eff),
        .head(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
    );

    spi_sfifo #(.WIDTH(REG_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .clr(rx_flush_q),
        .push(rx_push_eff), .push_data(rx_data), .pop(rd_data),
        .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
    );

    // interrupt events
    irq_flags_t set_flags, clr_flags, flags;
    logic       rc_hit;

    assign rc_hit = (8'(rx_count) + 8'd1 == 8'(rx_thr)) && (rx_thr != '0);

    always_comb begin
        set_flags     = '0;
        set_flags.ror = rx_push_eff && !rx_flush_q && !rx_push_ok;
        set_flags.rc  = rx_push_ok && !rx_pop_ok && rc_hit;
        set_flags.txc = tx_pop_ok && !tx_push_ok && (tx_count == CW'(1));
        clr_flags     = '0;
        clr_flags.ror = reg_wdata[B_ROR];
        clr_flags.rc  = reg_wdata[B_RC];
        clr_flags.txc = reg_wdata[B_TXC];
    end

    spi_irq_ctl u_irq (
        .clk(clk), .rst(rst),
        .set_flags(set_flags), .clr_we(wr_ist), .clr_flags(clr_flags),
        .en_rc(ie_rc), .en_ror(ie_ror),
        .flags(flags), .irq(irq)
    );

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_en     <= 1'b0;
            clk_cfg    <= '0;
            txw_cfg    <= '0;
            rxw_cfg    <= '0;
            frm_cfg    <= '0;
            ie_rc      <= 1'b0;
            ie_ror     <= 1'b0;
            tx_thr     <= '0;
            rx_thr     <= '0;
            tx_flush_q <= 1'b0;
            rx_flush_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctl_en  <= reg_wdata[0];
            if (wr_clk)  clk_cfg <= reg_wdata;
            if (wr_txw)  txw_cfg <= reg_wdata;
            if (wr_rxw)  rxw_cfg <= reg_wdata;
            if (wr_frm)  frm_cfg <= reg_wdata;
            if (wr_ien) begin
                ie_rc  <= reg_wdata[B_RC];
                ie_ror <= reg_wdata[B_ROR];
            end
            if (wr_fctl) begin
                tx_thr <= reg_wdata[B_TXTHR_LO +: THR_W];
                rx_thr <= reg_wdata[B_RXTHR_LO +: THR_W];
            end
            tx_flush_q <= wr_fctl && reg_wdata[B_TXFLUSH];
            rx_flush_q <= wr_fctl && reg_wdata[B_RXFLUSH];
        end
    end

    // read mux
    logic [REG_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        if (reg_addr[1:0] == 2'b00) begin
            case (reg_addr[5:2])
                RG_CTRL: rd_val[0] = ctl_en;
                RG_CLK:  rd_val = clk_cfg;
                RG_TXW:  rd_val = txw_cfg;
                RG_RXW:  rd_val = rxw_cfg;
                RG_FRM:  rd_val = frm_cfg;
                RG_STAT: rd_val[0] = !rx_empty;
                RG_IEN: begin
                    rd_val[B_RC]  = ie_rc;
                    rd_val[B_ROR] = ie_ror;
                end
                RG_IST: begin
                    rd_val[B_RXRDY] = !rx_empty;
                    rd_val[B_TXC]   = flags.txc;
                    rd_val[B_RC]    = flags.rc;
                    rd_val[B_ROR]   = flags.ror;
                end
                RG_FCTL: begin
                    rd_val[B_TXTHR_LO +: THR_W] = tx_thr;
                    rd_val[B_RXTHR_LO +: THR_W] = rx_thr;
                end
                RG_DATA: rd_val = rx_empty ? '0 : rx_head;
                default: rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_val;
    end

    assign reg_rdata   = rdata_q;
    assign tx_data     = tx_head;
    assign tx_avail    = !tx_empty;
    assign cfg_enable  = ctl_en;
    assign cfg_clock   = clk_cfg;
    assign cfg_tx_word = txw_cfg;
    assign cfg_rx_word = rxw_cfg;
    assign cfg_frame   = frm_cfg;

    // R5
    ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.ror) |-> $past(rx_push && ctl_en && rx_full && !rd_data));

    // R4
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && rx_empty) |=> (reg_rdata == '0));

    // R10
    flush_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && is_reg(reg_addr, RG_FCTL)) |=>
            (!reg_rdata[B_TXFLUSH] && !reg_rdata[B_RXFLUSH]));

    // R11
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_en && !rd_data && !rx_flush_q) |=> $stable(rx_count));

endmodule

// File: tb/spi_fifo_regs_tb.sv
`timescale 1ns/1ps
module spi_fifo_regs_tb;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_pop = 1'b0;
    logic [31:0] tx_data;
    logic        tx_avail;
    logic        rx_push = 1'b0;
    logic [31:0] rx_data = '0;
    logic        cfg_enable;
    logic [31:0] cfg_clock, cfg_tx_word, cfg_rx_word, cfg_frame;
    logic        irq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    spi_fifo_regs #(.FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_avail(tx_avail),
        .rx_push(rx_push), .rx_data(rx_data),
        .cfg_enable(cfg_enable), .cfg_clock(cfg_clock), .cfg_tx_word(cfg_tx_word),
        .cfg_rx_word(cfg_rx_word), .cfg_frame(cfg_frame), .irq(irq)
    );

    // behavioural reference model
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic        m_en, m_ie_rc, m_ie_ror, m_ror, m_rc, m_txc, m_ftx, m_frx;
    logic [31:0] m_cks, m_txw, m_rxw, m_frm, m_rdata, m_rv;
    logic [3:0]  m_txthr, m_rxthr;
    int          m_idx, m_txn, m_rxn;
    logic        m_ok, m_tpop, m_tpush, m_rpop, m_rreq, m_rpush, s_ror, s_rc, s_txc;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            txq.delete(); rxq.delete();
            m_en = 0; m_ie_rc = 0; m_ie_ror = 0; m_ror = 0; m_rc = 0; m_txc = 0;
            m_ftx = 0; m_frx = 0; m_cks = 0; m_txw = 0; m_rxw = 0; m_frm = 0;
            m_rdata = 0; m_txthr = 0; m_rxthr = 0;
        end else begin
            m_idx = int'(reg_addr[5:2]);
            m_ok  = (reg_addr[1:0] == 2'b00);
            m_txn = txq.size();
            m_rxn = rxq.size();
            m_tpop  = !m_ftx && m_en && tx_pop && m_txn > 0;
            m_tpush = !m_ftx && reg_wr && m_ok && m_idx == 9 && (m_txn < DEPTH || m_tpop);
            m_rpop  = !m_frx && reg_rd && m_ok && m_idx == 9 && m_rxn > 0;
            m_rreq  = !m_frx && m_en && rx_push;
            m_rpush = m_rreq && (m_rxn < DEPTH || m_rpop);
            s_ror = m_rreq && !m_rpush;
            s_rc  = m_rpush && !m_rpop && (m_rxn + 1 == int'(m_rxthr)) && m_rxthr != 0;
            s_txc = m_tpop && !m_tpush && m_txn == 1;
            m_rv = 0;
            if (m_ok) begin
                case (m_idx)
                    0: m_rv = {31'd0, m_en};
                    1: m_rv = m_cks;
                    2: m_rv = m_txw;
                    3: m_rv = m_rxw;
                    4: m_rv = m_frm;
                    5: m_rv = {31'd0, m_rxn > 0};
                    6: m_rv = {28'd0, m_ie_rc, 2'b00, m_ie_ror};
                    7: m_rv = {22'd0, m_rxn > 0, 4'd0, m_txc, m_rc, 2'b00, m_ror};
                    8: m_rv = {20'd0, m_txthr, 4'd0, m_rxthr};
                    9: m_rv = (m_rxn > 0) ? rxq[0] : 32'd0;
                    default: m_rv = 0;
                endcase
            end
            if (reg_rd) m_rdata = m_rv;
            if (m_ftx) txq.delete();
            else begin
                if (m_tpop)  void'(txq.pop_front());
                if (m_tpush) txq.push_back(reg_wdata);
            end
            if (m_frx) rxq.delete();
            else begin
                if (m_rpop)  void'(rxq.pop_front());
                if (m_rpush) rxq.push_back(rx_data);
            end
            if (reg_wr && m_ok && m_idx == 7) begin
                if (reg_wdata[0]) m_ror = 0;
                if (reg_wdata[3]) m_rc  = 0;
                if (reg_wdata[4]) m_txc = 0;
            end
            m_ror = m_ror | s_ror;
            m_rc  = m_rc  | s_rc;
            m_txc = m_txc | s_txc;
            m_ftx = 0; m_frx = 0;
            if (reg_wr && m_ok) begin
                case (m_idx)
                    0: m_en  = reg_wdata[0];
                    1: m_cks = reg_wdata;
                    2: m_txw = reg_wdata;
                    3: m_rxw = reg_wdata;
                    4: m_frm = reg_wdata;
                    6: begin m_ie_rc = reg_wdata[3]; m_ie_ror = reg_wdata[0]; end
                    8: begin
                        m_txthr = reg_wdata[11:8]; m_rxthr = reg_wdata[3:0];
                        m_ftx = reg_wdata[12];     m_frx = reg_wdata[4];
                    end
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R12 rdata vs model", reg_rdata, m_rdata);
            chk("R9 irq vs model", {31'd0, irq},
                {31'd0, (m_ie_rc && m_rc) || (m_ie_ror && m_ror)});
            chk("R3 tx_avail vs model", {31'd0, tx_avail}, {31'd0, txq.size() > 0});
            if (txq.size() > 0) chk("R3 tx_data vs model", tx_data, txq[0]);
            chk("R2 cfg vs model", {31'd0, cfg_enable}, {31'd0, m_en});
            chk("R2 cfg_clock vs model", cfg_clock, m_cks);
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); reg_rd = 0; d = reg_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); rx_push = 1; rx_data = d;
        @(negedge clk); rx_push = 0;
    endtask

    task automatic pop();
        @(negedge clk); tx_pop = 1;
        @(negedge clk); tx_pop = 0;
    endtask

    initial begin
        while (cycles < 200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected <200000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", reg_rdata, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 tx_avail", {31'd0, tx_avail}, 0);
        rdchk("R1 istat", 6'h1C, 0);
        rdchk("R1 status", 6'h14, 0);
        rdchk("R1 ctrl", 6'h00, 0);

        // R2 configuration
        wr(6'h04, 32'hA5A5_1234);
        rdchk("R2 clock reg", 6'h04, 32'hA5A5_1234);
        wr(6'h10, 32'h0000_C001);
        chk("R2 cfg_frame", cfg_frame, 32'h0000_C001);
        wr(6'h00, 32'hFFFF_FFFF);
        rdchk("R2 ctrl bit0", 6'h00, 1);
        chk("R2 cfg_enable", {31'd0, cfg_enable}, 1);
        rdchk("R2 unmapped", 6'h28, 0);
        rdchk("R2 misaligned", 6'h06, 0);

        // R3 transmit queue
        for (int i = 0; i < 5; i++) wr(6'h24, 32'h11 + i);
        chk("R3 head", tx_data, 32'h11);
        pop();
        chk("R3 after pop", tx_data, 32'h12);
        for (int i = 0; i < 4; i++) wr(6'h24, 32'h16 + i);
        wr(6'h24, 32'h99);
        for (int i = 0; i < 8; i++) begin
            chk("R3 order", tx_data, 32'h12 + i);
            pop();
        end
        chk("R3 drained, full write dropped", {31'd0, tx_avail}, 0);
        // R7 transmit complete
        rdchk("R7 txc flag", 6'h1C, 32'h10);
        wr(6'h1C, 32'h10);
        rdchk("R8 txc cleared", 6'h1C, 0);

        // R6 receive complete at threshold
        wr(6'h20, 32'h0303);
        rdchk("R10 thresholds", 6'h20, 32'h0303);
        push(32'hA1); push(32'hA2);
        rdchk("R6 below threshold", 6'h1C, 32'h200);
        rdchk("R4 not empty", 6'h14, 1);
        push(32'hA3);
        rdchk("R6 reached", 6'h1C, 32'h208);
        chk("R9 irq masked", {31'd0, irq}, 0);
        wr(6'h18, 32'hFFFF_FFFF);
        chk("R9 irq enabled", {31'd0, irq}, 1);
        rdchk("R9 ie readback", 6'h18, 32'h9);
        rdchk("R4 word 0", 6'h24, 32'hA1);
        rdchk("R4 word 1", 6'h24, 32'hA2);
        rdchk("R4 word 2", 6'h24, 32'hA3);
        rdchk("R4 empty read", 6'h24, 0);
        rdchk("R4 empty status", 6'h14, 0);
        rdchk("R6 sticky", 6'h1C, 32'h008);
        wr(6'h1C, 32'h8);
        chk("R8 irq after clear", {31'd0, irq}, 0);

        // R5 overrun
        for (int i = 0; i < 9; i++) push(32'hB0 + i);
        rdchk("R5 overrun flag", 6'h1C, 32'h209);
        chk("R5 irq", {31'd0, irq}, 1);
        for (int i = 0; i < 8; i++) rdchk("R5 order kept", 6'h24, 32'hB0 + i);
        wr(6'h1C, 32'h1);
        rdchk("R8 partial clear", 6'h1C, 32'h008);
        wr(6'h1C, 32'h8);
        rdchk("R8 all clear", 6'h1C, 0);

        // R10 flush
        push(32'hC0); push(32'hC1);
        wr(6'h24, 32'hD0); wr(6'h24, 32'hD1);
        wr(6'h20, 32'h1313);
        rdchk("R10 flush bits read 0", 6'h20, 32'h0303);
        rdchk("R10 rx flushed", 6'h14, 0);
        chk("R10 tx flushed", {31'd0, tx_avail}, 0);

        // R11 disabled
        wr(6'h00, 0);
        push(32'hE0);
        rdchk("R11 push ignored", 6'h14, 0);
        wr(6'h24, 32'hF0);
        pop();
        chk("R11 pop ignored avail", {31'd0, tx_avail}, 1);
        chk("R11 pop ignored data", tx_data, 32'hF0);
        wr(6'h00, 1);
        pop();
        chk("R3 popped after enable", {31'd0, tx_avail}, 0);
        wr(6'h1C, 32'h10);

        // R8 set wins over clear in the same cycle
        wr(6'h20, 32'h0101);
        @(negedge clk);
        rx_push = 1; rx_data = 32'h6;
        reg_wr = 1; reg_addr = 6'h1C; reg_wdata = 32'h8;
        @(negedge clk);
        rx_push = 0; reg_wr = 0;
        rdchk("R8 set wins", 6'h1C, 32'h208);
        rdchk("R4 word", 6'h24, 32'h6);
        wr(6'h1C, 32'h19);
        rdchk("R8 final clear", 6'h1C, 0);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule